// File: doc/BRIEF.md
# FIFO Flag Offset Loader

This block owns the two threshold values a FIFO uses for its partial-fill flags: the low-water offset (compared against words held, for the almost-empty flag) and the high-water offset (compared against free locations, for the almost-full flag). The flag comparison logic and the storage array live elsewhere; this block only produces the two offsets, a done indication, and a gated write enable for the FIFO.

The loading method is latched while the master reset is held low, from three configuration pins. It can be a fixed preset, a parallel load from the write data bus, or a serial load. Two of the three configuration pins are reused after reset as the active-low serial enable and the serial data bit. The serial chain is twice the offset width long and runs MSB first: it fills the high-water register first and the low-water register last. Until the chosen method has finished, writes are kept away from the FIFO.

Offset width is `$clog2(DEPTH)`, so the default depth of 8192 gives 13-bit offsets and a 26-bit serial load. DEPTH must be at least 2048 so that the largest preset fits.

Top module: `ofs_loader`

## Requirements
- R1: While `rst_n` is low, `prog_done` and `fifo_wr_en` are both low, whatever `wr_en` does.
- R2: The select code is {`cfg_hi`,`cfg_sen_n`,`cfg_sd`}, sampled while `rst_n` is low. Codes 000, 010, 100, 101 and 110 are presets 8, 16, 64, 256 and 1024. After a preset reset, both offsets equal the preset value and `prog_done` is high within five clock cycles of `rst_n` rising.
- R3: The select code is held from the last clock before the reset is released. Changing the configuration pins afterwards changes neither the mode nor the offsets.
- R4: Codes 011 and 111 select serial loading. Each rising clock edge with `cfg_sen_n` low shifts `cfg_sd` into a 2*log2(DEPTH)-bit chain {high-water, low-water}. The first bit ends up as the high-water MSB and the last bit as the low-water LSB.
- R5: In serial mode, `prog_done` stays low until the final chain bit has been shifted, and rises on the edge that shifts that bit.
- R6: In serial mode, clock edges with `cfg_sen_n` high shift nothing.
- R7: Once `prog_done` is high it stays high, and later serial enable pulses or data words leave both offsets unchanged.
- R8: Code 001 selects parallel loading. The first `wr_en` cycle after reset loads the low-water offset from `wr_data[log2(DEPTH)-1:0]`. The second loads the high-water offset and completes programming.
- R9: `fifo_wr_en` is low while `prog_done` is low, including during the parallel load writes. After that it follows `wr_en`.
- R10: A new reset restarts programming with the newly sampled code, even when a serial load has not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| cfg_sd | input | 1 | Select bit 0 during reset; serial data bit afterwards |
| cfg_sen_n | input | 1 | Select bit 1 during reset; active-low serial enable afterwards |
| cfg_hi | input | 1 | Select bit 2, used only during reset |
| wr_en | input | 1 | Write strobe on the data port |
| wr_data | input | DATA_W | Write data bus |
| fifo_wr_en | output | 1 | Write strobe passed on to FIFO storage |
| ofs_empty | output | log2(DEPTH) | Low-water offset for the almost-empty flag |
| ofs_full | output | log2(DEPTH) | High-water offset for the almost-full flag |
| prog_done | output | 1 | Offsets are programmed and final |

## Verification
Several properties are checked on every cycle. Once set, the done flag stays high and both offsets stay frozen. The latched mode never changes after reset is released. A preset reset always completes. The serial bit counter steps by one per enabled edge and never passes the chain length. Parallel loads never hit the same register twice in a row. Some behaviour can only be shown by the bench's scenarios, because it depends on the values driven in: the select code table, the MSB-first placement of serial bits across both registers, idle edges shifting nothing, the bit slice used by parallel loads, gating of writes while loading, and a restart on a fresh reset.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

  typedef enum logic [1:0] {
    LM_PRESET   = 2'd0,
    LM_PARALLEL = 2'd1,
    LM_SERIAL   = 2'd2
  } load_mode_e;

  localparam int PRESET_W = 11;

  typedef struct packed {
    load_mode_e            mode;
    logic [PRESET_W-1:0]   preset;
  } load_cfg_t;

  // select code = {hi, sen_n, sd}
  function automatic load_cfg_t decode_select(input logic [2:0] code);
    load_cfg_t c;
    c.mode   = LM_PRESET;
    c.preset = '0;
    case (code)
      3'b000:  c.preset = PRESET_W'(8);
      3'b001:  c.mode   = LM_PARALLEL;
      3'b010:  c.preset = PRESET_W'(16);
      3'b100:  c.preset = PRESET_W'(64);
      3'b101:  c.preset = PRESET_W'(256);
      3'b110:  c.preset = PRESET_W'(1024);
      default: c.mode   = LM_SERIAL;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/ofs_serial_ctrl.sv
module ofs_serial_ctrl #(
  parameter int BITS = 26
) (
  input  logic clk,
  input  logic srst_n,
  input  logic arm,
  input  logic sen_n,
  output logic shift,
  output logic last
);

  localparam int CW = $clog2(BITS + 1);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    shift    = arm && !sen_n && (count_q != CW'(BITS));
    last     = shift && (count_q == CW'(BITS - 1));
    count_en = shift;
    count_d  = count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!srst_n)
    count_q <= CW'(BITS));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!srst_n)
    shift |=> (count_q == $past(count_q) + CW'(1)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!arm || sen_n) |=> $stable(count_q));

endmodule

// File: rtl/ofs_par_ctrl.sv
module ofs_par_ctrl (
  input  logic clk,
  input  logic srst_n,
  input  logic arm,
  input  logic wr_en,
  output logic load_lo,
  output logic load_hi
);

  typedef enum logic [1:0] {
    PS_WAIT_LO = 2'd0,
    PS_WAIT_HI = 2'd1,
    PS_FINISH  = 2'd2
  } par_state_e;

  par_state_e state_q;
  par_state_e state_d;
  logic       take;

  always_comb begin
    take    = arm && wr_en;
    load_lo = take && (state_q == PS_WAIT_LO);
    load_hi = take && (state_q == PS_WAIT_HI);
    state_d = state_q;
    if (load_lo) state_d = PS_WAIT_HI;
    if (load_hi) state_d = PS_FINISH;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= PS_WAIT_LO;
    end else begin
      state_q <= state_d;
    end
  end

  p_lo_once_r8: assert property (@(posedge clk) disable iff (!srst_n)
    load_lo |=> !load_lo);

  p_one_target_r8: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({load_lo, load_hi}));

endmodule

// File: rtl/ofs_offset_regs.sv
module ofs_offset_regs #(
  parameter int OFS_W = 13
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [OFS_W-1:0] init_val,
  input  logic             shift,
  input  logic             sdat,
  input  logic             load_lo,
  input  logic             load_hi,
  input  logic [OFS_W-1:0] par_val,
  output logic [OFS_W-1:0] lo_ofs,
  output logic [OFS_W-1:0] hi_ofs
);

  localparam int CHAIN_W = 2 * OFS_W;

  // chain = {high-water, low-water}; MSB shifts in first
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (!srst_n) begin
      chain_d = {init_val, init_val};
    end else if (shift) begin
      chain_d = {chain_q[CHAIN_W-2:0], sdat};
    end else if (load_lo) begin
      chain_d[OFS_W-1:0] = par_val;
    end else if (load_hi) begin
      chain_d[CHAIN_W-1:OFS_W] = par_val;
    end
  end

  always_ff @(posedge clk) begin
    chain_q <= chain_d;
  end

  assign lo_ofs = chain_q[OFS_W-1:0];
  assign hi_ofs = chain_q[CHAIN_W-1:OFS_W];

  p_lo_keeps_hi_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (load_lo && !shift) |=> $stable(hi_ofs));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader #(
  parameter int DEPTH  = 8192,
  parameter int DATA_W = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_sd,
  input  logic                       cfg_sen_n,
  input  logic                       cfg_hi,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic                       fifo_wr_en,
  output logic [$clog2(DEPTH)-1:0]   ofs_empty,
  output logic [$clog2(DEPTH)-1:0]   ofs_full,
  output logic                       prog_done
);
  import ofs_loader_pkg::*;

  localparam int OFS_W  = $clog2(DEPTH);
  localparam int SER_NB = 2 * OFS_W;

  logic             srst_n;
  load_cfg_t        cfg_d;
  load_cfg_t        cfg_q;
  logic [OFS_W-1:0] init_val;
  logic             ser_arm;
  logic             par_arm;
  logic             ser_shift;
  logic             ser_last;
  logic             load_lo;
  logic             load_hi;
  logic             done_q;
  logic             done_d;
  logic             unused_data_hi;

  ofs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // mode capture: follows the pins while reset is held
  always_comb begin
    cfg_d = decode_select({cfg_hi, cfg_sen_n, cfg_sd});
    if (srst_n) cfg_d = cfg_q;
    init_val = (cfg_d.mode == LM_PRESET) ? OFS_W'(cfg_d.preset) : '0;
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  always_comb begin
    ser_arm = (cfg_q.mode == LM_SERIAL) && !done_q;
    par_arm = (cfg_q.mode == LM_PARALLEL) && !done_q;
  end

  ofs_serial_ctrl #(.BITS(SER_NB)) u_ser (
    .clk    (clk),
    .srst_n (srst_n),
    .arm    (ser_arm),
    .sen_n  (cfg_sen_n),
    .shift  (ser_shift),
    .last   (ser_last)
  );

  ofs_par_ctrl u_par (
    .clk     (clk),
    .srst_n  (srst_n),
    .arm     (par_arm),
    .wr_en   (wr_en),
    .load_lo (load_lo),
    .load_hi (load_hi)
  );

  ofs_offset_regs #(.OFS_W(OFS_W)) u_regs (
    .clk      (clk),
    .srst_n   (srst_n),
    .init_val (init_val),
    .shift    (ser_shift),
    .sdat     (cfg_sd),
    .load_lo  (load_lo),
    .load_hi  (load_hi),
    .par_val  (wr_data[OFS_W-1:0]),
    .lo_ofs   (ofs_empty),
    .hi_ofs   (ofs_full)
  );

  generate
    if (DATA_W > OFS_W) begin : g_spare
      assign unused_data_hi = ^wr_data[DATA_W-1:OFS_W];
    end else begin : g_nospare
      assign unused_data_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    done_d = done_q || (cfg_q.mode == LM_PRESET) || ser_last || load_hi;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign prog_done  = done_q;
  assign fifo_wr_en = wr_en && done_q;

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!srst_n)
    done_q |=> done_q);

  p_offsets_frozen_r7: assert property (@(posedge clk) disable iff (!srst_n)
    done_q |=> ($stable(ofs_empty) && $stable(ofs_full)));

  p_mode_held_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $past(srst_n) |-> $stable(cfg_q));

  p_preset_done_r2: assert property (@(posedge clk) disable iff (!srst_n)
    ((cfg_q.mode == LM_PRESET) && $past(srst_n)) |-> done_q);

  p_serial_no_early_r5: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(done_q) && (cfg_q.mode == LM_SERIAL)) |-> $past(ser_last));

endmodule

// File: tb/sim_ofs_loader.sv
module sim_ofs_loader;
  localparam int DEPTH = 8192;
  localparam int DW    = 36;
  localparam int W     = 13;
  localparam int NB    = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          cfg_sd = 1'b0;
  logic          cfg_sen_n = 1'b1;
  logic          cfg_hi = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          fifo_wr_en;
  logic [W-1:0]  ofs_empty;
  logic [W-1:0]  ofs_full;
  logic          prog_done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ofs_loader #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sd(cfg_sd), .cfg_sen_n(cfg_sen_n),
    .cfg_hi(cfg_hi), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_wr_en(fifo_wr_en), .ofs_empty(ofs_empty), .ofs_full(ofs_full),
    .prog_done(prog_done)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    {cfg_hi, cfg_sen_n, cfg_sd} = code;
    wr_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", prog_done, 0);
    check("R1", "fifo write in reset", fifo_wr_en, 0);
    wr_en = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    cfg_sen_n = 1'b0;
    cfg_sd    = b;
    @(negedge clk);
    cfg_sen_n = 1'b1;
  endtask

  task automatic t_presets();
    logic [2:0] codes [5] = '{3'b000, 3'b010, 3'b100, 3'b101, 3'b110};
    int         vals  [5] = '{8, 16, 64, 256, 1024};
    for (int i = 0; i < 5; i++) begin
      do_reset(codes[i]);
      check("R2", "preset done", prog_done, 1);
      check("R2", "preset low-water", ofs_empty, vals[i]);
      check("R2", "preset high-water", ofs_full, vals[i]);
    end
    // pins wiggle after reset: nothing may change
    cfg_hi = 1'b0; cfg_sd = 1'b1;
    for (int k = 0; k < 4; k++) shift_bit(k[0]);
    check("R3", "low-water after pin change", ofs_empty, 1024);
    check("R3", "high-water after pin change", ofs_full, 1024);
    wr_en = 1'b1;
    #1 check("R9", "write passes after done", fifo_wr_en, 1);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9", "write idle after done", fifo_wr_en, 0);
  endtask

  task automatic t_serial(input logic [2:0] code, input logic [W-1:0] hv,
                          input logic [W-1:0] lv);
    logic [NB-1:0] pat = {hv, lv};
    do_reset(code);
    check("R4", "serial not done at start", prog_done, 0);
    for (int i = NB - 1; i >= 1; i--) begin
      shift_bit(pat[i]);
      if (i == NB / 2) begin
        wr_en = 1'b1;
        #1 check("R9", "write blocked in serial", fifo_wr_en, 0);
        cfg_sd = ~cfg_sd;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
      end
    end
    check("R5", "done before last bit", prog_done, 0);
    shift_bit(pat[0]);
    check("R5", "done after last bit", prog_done, 1);
    check("R4", "serial low-water", ofs_empty, lv);
    check("R6", "serial high-water (idle edges)", ofs_full, hv);
    for (int k = 0; k < 5; k++) shift_bit(~pat[k]);
    check("R7", "low-water after extra bits", ofs_empty, lv);
    check("R7", "high-water after extra bits", ofs_full, hv);
    check("R7", "done stays", prog_done, 1);
  endtask

  task automatic t_parallel();
    do_reset(3'b001);
    check("R8", "parallel not done", prog_done, 0);
    wr_en = 1'b1;
    wr_data = 36'hF_FFFF_EABC;
    #1 check("R9", "first load write blocked", fifo_wr_en, 0);
    @(negedge clk);
    wr_data = 36'h1_2345_1357;
    #1 check("R9", "second load write blocked", fifo_wr_en, 0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", "parallel low-water", ofs_empty, 13'h0ABC);
    check("R8", "parallel high-water", ofs_full, 13'h1357);
    check("R8", "parallel done", prog_done, 1);
    wr_en = 1'b1;
    wr_data = 36'h0_0000_0001;
    #1 check("R9", "third write to fifo", fifo_wr_en, 1);
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", "low-water after data write", ofs_empty, 13'h0ABC);
    check("R7", "high-water after data write", ofs_full, 13'h1357);
  endtask

  task automatic t_restart();
    do_reset(3'b011);
    for (int k = 0; k < 5; k++) shift_bit(1'b1);
    check("R10", "partial serial not done", prog_done, 0);
    do_reset(3'b100);
    check("R10", "restart done", prog_done, 1);
    check("R10", "restart low-water", ofs_empty, 64);
    check("R10", "restart high-water", ofs_full, 64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_presets();
    t_serial(3'b011, 13'h1A5B, 13'h0C37);
    t_serial(3'b111, 13'h0F01, 13'h10FE);
    t_parallel();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule